// File: doc/BRIEF.md
# Comparator Level Encoder with Selectable Output Format

This block is the digital back end of a flash analog-to-digital converter. A bank of comparators, one per reference level, presents a vector in which every comparator below the analog input reads 1 and every comparator above it reads 0. The block counts the position of the 1-to-0 boundary in that vector and presents it as an unsigned or offset-signed number. Either form can be given in true or complemented sense.

A sample is taken on a rising clock edge when `sample_en` is high. The comparator vector is held in a capture register and is decoded combinationally from it. The code for a sample is therefore on `code_o` right after the edge that took it, with no further register stage. The previous code stays unchanged until the next capture, so a downstream register may latch either value.

The two format bits are treated as static levels and are not tied to the sample timing. Changing them recodes the held sample immediately. Before the boundary is located, each comparator bit is replaced by the two-of-three majority of itself and its two neighbours. This removes isolated wrong bits (bubbles) that would otherwise corrupt the count.

Top module: `thermo_code_encoder`

## Requirements
- R1: While `rst_n` is low, the held sample is cleared, so `code_o` is 0 with `fmt_i` = 2'b00 whatever `thermo_i` and `sample_en` carry.
- R2: With `fmt_i` = 2'b00, capturing a vector whose bits 0..k-1 are 1 and the rest 0 gives `code_o` = k, for every k from 0 to 127.
- R3: The all-zero vector (input below the lowest threshold) yields code 0 in the unsigned form. The all-one vector (input above the highest threshold) yields code 127.
- R4: `fmt_i` = 2'b01 complements only bit 6 of the unsigned count, giving offset two's complement.
- R5: `fmt_i` = 2'b10 complements only bits 5..0 of the unsigned count.
- R6: `fmt_i` = 2'b11 complements all seven bits of the unsigned count.
- R7: A change on `fmt_i` changes `code_o` within the same clock cycle, without a new capture.
- R8: The code for a captured vector is on `code_o` right after the capturing edge. While `sample_en` is low and `fmt_i` is steady, `code_o` does not change, whatever `thermo_i` does.
- R9: For a clean level k, one wrong bit at position j gives the same code k as the clean vector. This holds for a 0 at j ≤ k-3 or a 1 at j ≥ k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Capture `thermo_i` on this rising edge |
| fmt_i | input | 2 | Format select: bit 0 complements the MSB, bit 1 complements the lower bits |
| thermo_i | input | 127 | Comparator outputs, bit i for the i-th reference level from the bottom |
| code_o | output | 7 | Encoded sample |

## Verification
The bench builds the block with its default seven-bit resolution (127 comparators) and with majority voting enabled. At that size every one of the 128 levels can be swept exhaustively under each of the four formats. Single-bit bubbles can be placed on both sides of the boundary across the whole range. The full-scale ends and the held-code behaviour between captures are also within reach at this size.

// File: rtl/thermo_pkg.sv
package thermo_pkg;

    typedef enum logic [1:0] {
        FMT_BIN     = 2'b00,
        FMT_OFS     = 2'b01,
        FMT_OFS_INV = 2'b10,
        FMT_BIN_INV = 2'b11
    } fmt_e;

    // Format bit that complements the top bit of the code.
    function automatic logic flips_msb(input logic [1:0] fmt);
        return fmt[0];
    endfunction

    // Format bit that complements every bit below the top one.
    function automatic logic flips_lsbs(input logic [1:0] fmt);
        return fmt[1];
    endfunction

endpackage

// File: rtl/thermo_bubble_vote.sv
module thermo_bubble_vote #(
    parameter int LEVELS = 127,
    parameter bit ENABLE = 1'b1
) (
    input  logic [LEVELS-1:0] raw_i,
    output logic [LEVELS-1:0] clean_o
);

    localparam int EXT_W = LEVELS + 2;

    // Padded vector: a virtual 1 below the first comparator and a virtual 0 above the last.
    logic [EXT_W-1:0] ext;
    assign ext = {1'b0, raw_i, 1'b1};

    generate
        if (ENABLE) begin : g_vote
            for (genvar i = 0; i < LEVELS; i++) begin : g_bit
                logic lo, mid, hi;
                assign lo  = ext[i];
                assign mid = ext[i+1];
                assign hi  = ext[i+2];
                assign clean_o[i] = (lo & mid) | (mid & hi) | (lo & hi);
            end
        end else begin : g_pass
            assign clean_o = ext[LEVELS:1];
        end
    endgenerate

endmodule

// File: rtl/thermo_edge_find.sv
module thermo_edge_find #(
    parameter int LEVELS = 127
) (
    input  logic [LEVELS-1:0] therm_i,
    output logic [LEVELS-1:0] hot_o    // hot_o[i] marks a count of i+1
);

    generate
        for (genvar i = 0; i < LEVELS; i++) begin : g_edge
            if (i == LEVELS - 1) begin : g_top
                assign hot_o[i] = therm_i[i];
            end else begin : g_mid
                assign hot_o[i] = therm_i[i] & ~therm_i[i+1];
            end
        end
    endgenerate

endmodule

// File: rtl/thermo_onehot_bin.sv
module thermo_onehot_bin #(
    parameter int LEVELS   = 127,
    parameter int RES_BITS = 7
) (
    input  logic [LEVELS-1:0]   hot_i,
    output logic [RES_BITS-1:0] bin_o
);

    always_comb begin
        bin_o = '0;
        for (int i = 0; i < LEVELS; i++) begin
            logic [RES_BITS-1:0] val;
            val = RES_BITS'(i + 1);
            if (hot_i[i]) begin
                bin_o = bin_o | val;
            end
        end
    end

endmodule

// File: rtl/thermo_code_format.sv
module thermo_code_format
    import thermo_pkg::*;
#(
    parameter int RES_BITS = 7
) (
    input  logic [RES_BITS-1:0] bin_i,
    input  logic [1:0]          fmt_i,
    output logic [RES_BITS-1:0] code_o
);

    localparam int LOW_W = RES_BITS - 1;

    logic [RES_BITS-1:0] flip;

    always_comb begin
        flip = {flips_msb(fmt_i), {LOW_W{flips_lsbs(fmt_i)}}};
        code_o = bin_i ^ flip;
    end

endmodule

// File: rtl/thermo_code_encoder.sv
module thermo_code_encoder #(
    parameter int RES_BITS      = 7,
    parameter bit BUBBLE_FILTER = 1'b1,
    parameter int LEVELS        = (1 << RES_BITS) - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_en,
    input  logic [1:0]          fmt_i,
    input  logic [LEVELS-1:0]   thermo_i,
    output logic [RES_BITS-1:0] code_o
);

    typedef struct packed {
        logic [LEVELS-1:0] therm;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sample_en) begin
            st_d.therm = thermo_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic [LEVELS-1:0]   voted;
    logic [LEVELS-1:0]   hot;
    logic [RES_BITS-1:0] bin_code;

    thermo_bubble_vote #(.LEVELS(LEVELS), .ENABLE(BUBBLE_FILTER)) u_vote (
        .raw_i   (st_q.therm),
        .clean_o (voted)
    );

    thermo_edge_find #(.LEVELS(LEVELS)) u_edge (
        .therm_i (voted),
        .hot_o   (hot)
    );

    thermo_onehot_bin #(.LEVELS(LEVELS), .RES_BITS(RES_BITS)) u_bin (
        .hot_i (hot),
        .bin_o (bin_code)
    );

    thermo_code_format #(.RES_BITS(RES_BITS)) u_fmt (
        .bin_i  (bin_code),
        .fmt_i  (fmt_i),
        .code_o (code_o)
    );

endmodule

// File: rtl/thermo_encoder_chk.sv
module thermo_encoder_chk #(
    parameter int RES_BITS = 7,
    parameter int LEVELS   = (1 << RES_BITS) - 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sample_en,
    input logic [1:0]          fmt_i,
    input logic [LEVELS-1:0]   thermo_i,
    input logic [RES_BITS-1:0] code_o
);

    localparam logic [RES_BITS-1:0] TOP_ONLY = RES_BITS'(1) << (RES_BITS - 1);
    localparam logic [RES_BITS-1:0] ALL_ONES = '1;
    localparam logic [RES_BITS-1:0] LOW_ONLY = ALL_ONES ^ TOP_ONLY;

    logic [RES_BITS-1:0] in_count;
    logic                in_clean;
    logic [RES_BITS-1:0] undo;
    logic [RES_BITS-1:0] unsigned_code;

    always_comb begin
        in_count = RES_BITS'($countones(thermo_i));
        in_clean = 1'b1;
        for (int i = 0; i < LEVELS; i++) begin
            if (thermo_i[i] != (i < int'(in_count))) begin
                in_clean = 1'b0;
            end
        end
        undo = (fmt_i[0] ? TOP_ONLY : '0) | (fmt_i[1] ? LOW_ONLY : '0);
        unsigned_code = code_o ^ undo;
    end

    assert_clean_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && in_clean) |=> (unsigned_code == $past(in_count)));

    assert_below_scale_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && (thermo_i == '0)) |=> (unsigned_code == '0));

    assert_above_scale_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && (&thermo_i)) |=> (unsigned_code == ALL_ONES));

    assert_offset_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_en && fmt_i == 2'b00) |=> ((fmt_i == 2'b01) -> (code_o == ($past(code_o) ^ TOP_ONLY))));

    assert_low_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_en && fmt_i == 2'b00) |=> ((fmt_i == 2'b10) -> (code_o == ($past(code_o) ^ LOW_ONLY))));

    assert_full_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_en && fmt_i == 2'b00) |=> ((fmt_i == 2'b11) -> (code_o == ($past(code_o) ^ ALL_ONES))));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_en) |=> ($stable(fmt_i) -> $stable(code_o)));

endmodule

bind thermo_code_encoder thermo_encoder_chk #(.RES_BITS(RES_BITS), .LEVELS(LEVELS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (sample_en),
    .fmt_i     (fmt_i),
    .thermo_i  (thermo_i),
    .code_o    (code_o)
);

// File: tb/tb_thermo_code_encoder.sv
`timescale 1ns/1ps
module tb_thermo_code_encoder;

    localparam int RES = 7;
    localparam int L   = (1 << RES) - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           sample_en = 1'b0;
    logic [1:0]     fmt = 2'b00;
    logic [L-1:0]   thermo = '0;
    logic [RES-1:0] code;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    thermo_code_encoder #(.RES_BITS(RES), .BUBBLE_FILTER(1'b1)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .fmt_i     (fmt),
        .thermo_i  (thermo),
        .code_o    (code)
    );

    function automatic logic [L-1:0] level(input int k);
        logic [L-1:0] v;
        v = '0;
        for (int i = 0; i < L; i++) begin
            if (i < k) v[i] = 1'b1;
        end
        return v;
    endfunction

    // Expected code from the requirement text: bit 0 of fmt flips bit 6, bit 1 flips bits 5..0.
    function automatic logic [RES-1:0] expect_code(input int k, input logic [1:0] f);
        logic [RES-1:0] c;
        c = RES'(k);
        if (f[0]) c[RES-1] = ~c[RES-1];
        if (f[1]) c[RES-2:0] = ~c[RES-2:0];
        return c;
    endfunction

    task automatic check(input string req, input logic [RES-1:0] act, input logic [RES-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic capture(input logic [L-1:0] v);
        @(negedge clk);
        thermo = v;
        sample_en = 1'b1;
        @(negedge clk);
        sample_en = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        thermo = '1;
        sample_en = 1'b1;
        fmt = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 in reset", code, '0);
        sample_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", code, '0);
    endtask

    task automatic t_sweep;
        fmt = 2'b00;
        for (int k = 0; k <= L; k++) begin
            capture(level(k));
            check("R2 level sweep", code, expect_code(k, 2'b00));
        end
    endtask

    task automatic t_ends;
        for (int f = 0; f < 4; f++) begin
            fmt = 2'(f);
            capture('0);
            check("R3 below scale", code, expect_code(0, 2'(f)));
            capture('1);
            check("R3 above scale", code, expect_code(L, 2'(f)));
        end
        fmt = 2'b00;
    endtask

    task automatic t_formats;
        int pts[6] = '{0, 1, 63, 64, 100, 127};
        foreach (pts[p]) begin
            fmt = 2'b01;
            capture(level(pts[p]));
            check("R4 offset msb", code, expect_code(pts[p], 2'b01));
            fmt = 2'b10;
            capture(level(pts[p]));
            check("R5 low six flipped", code, expect_code(pts[p], 2'b10));
            fmt = 2'b11;
            capture(level(pts[p]));
            check("R6 all flipped", code, expect_code(pts[p], 2'b11));
        end
        fmt = 2'b00;
    endtask

    task automatic t_live_format;
        fmt = 2'b00;
        capture(level(37));
        check("R7 base", code, expect_code(37, 2'b00));
        for (int f = 1; f < 4; f++) begin
            @(negedge clk);
            fmt = 2'(f);
            #2;
            check("R7 same-cycle recode", code, expect_code(37, 2'(f)));
        end
        @(negedge clk);
        fmt = 2'b00;
        #2;
        check("R7 back to unsigned", code, expect_code(37, 2'b00));
    endtask

    task automatic t_hold_and_latency;
        fmt = 2'b00;
        capture(level(50));
        @(negedge clk);
        thermo = level(90);
        repeat (3) @(posedge clk);
        #1;
        check("R8 held while idle", code, 7'd50);
        @(negedge clk);
        thermo = '1;
        #1;
        check("R8 held on input change", code, 7'd50);
        @(negedge clk);
        thermo = level(12);
        sample_en = 1'b1;
        @(posedge clk);
        #1;
        check("R8 valid after capture edge", code, 7'd12);
        @(negedge clk);
        sample_en = 1'b0;
    endtask

    task automatic t_bubbles;
        fmt = 2'b00;
        for (int k = 0; k <= L; k += 7) begin
            if (k >= 3) begin
                for (int j = 0; j <= k - 3; j += 11) begin
                    logic [L-1:0] v;
                    v = level(k);
                    v[j] = 1'b0;
                    capture(v);
                    check("R9 hole below edge", code, RES'(k));
                end
            end
            if (k + 2 <= L - 1) begin
                for (int j = k + 2; j <= L - 1; j += 13) begin
                    logic [L-1:0] v;
                    v = level(k);
                    v[j] = 1'b1;
                    capture(v);
                    check("R9 spike above edge", code, RES'(k));
                end
            end
        end
        capture(level(L) ^ (L'(1) << (L - 3)));
        check("R9 hole near top", code, RES'(L));
        capture(L'(1) << 2);
        check("R9 spike near bottom", code, '0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_sweep();
        t_ends();
        t_formats();
        t_live_format();
        t_hold_and_latency();
        t_bubbles();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule